// File: doc/BRIEF.md
# Two-Line Interrupt Aggregator

This block collects up to eighteen peripheral interrupt sources into a sticky pending register. It combines them with a software-controlled enable mask and drives two active-low processor request lines. Source 0 is the only source that can pull the fast-interrupt line low. Every other source, once masked, is ORed onto the normal-interrupt line.

Peripherals report events with single-cycle set pulses. Software controls the block through a one-cycle write port. Each write carries a command and a bit vector: the command enables mask bits, disables mask bits, or clears pending bits. A write changes only the bits where the data has a 1. The pending and mask registers are visible at all times on output ports. The block does no vectoring, priority encoding, nesting or end-of-interrupt handling.

Top module: `irq_aggregator`

## Requirements
- R1: While `rst_ni` is low, `pend_o` and `mask_o` are all zero and both `fiq_no` and `irq_no` are high. Reset is asynchronous.
- R2: A 1 on `set_i[n]` at a rising clock edge makes `pend_o[n]` 1 after that edge. The bit then stays 1 until a clear command removes it.
- R3: A write with `wr_cmd_i` = 2'b00 (enable) sets `mask_o` bits where `wr_data_i` is 1. Bits where the data is 0 are left unchanged.
- R4: A write with `wr_cmd_i` = 2'b01 (disable) clears `mask_o` bits where `wr_data_i` is 1. Other bits are left unchanged.
- R5: A write with `wr_cmd_i` = 2'b10 (clear) clears `pend_o` bits where `wr_data_i` is 1. Other pending bits are left unchanged.
- R6: If a set pulse and a clear command hit the same bit in the same cycle, the bit ends up 1.
- R7: `fiq_no` is low exactly when `pend_o[0]` and `mask_o[0]` are both 1.
- R8: `irq_no` is low exactly when some bit n in 1..17 has both `pend_o[n]` and `mask_o[n]` equal to 1.
- R9: A write with `wr_cmd_i` = 2'b11, or any cycle with `wr_en_i` low, leaves `pend_o` and `mask_o` unchanged.
- R10: A set pulse records the pending bit whether or not its mask bit is 1. While the source is masked, its pending bit drives neither line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| set_i | input | 18 | Per-source single-cycle request pulses |
| wr_en_i | input | 1 | Write strobe for the command port |
| wr_cmd_i | input | 2 | 00 enable, 01 disable, 10 clear pending, 11 no-op |
| wr_data_i | input | 18 | Bit vector the command acts on |
| pend_o | output | 18 | Pending register |
| mask_o | output | 18 | Enable mask register |
| fiq_no | output | 1 | Fast interrupt request, active low |
| irq_no | output | 1 | Normal interrupt request, active low |

## Verification
The bench targets the cycle in which a set pulse and a clear for the same bit coincide. A design that gave priority to the clear would lose the event and read 0 there. It also drives the reserved command and writes with the strobe low, with all-ones data. Both must leave the registers untouched; a decoder that ignores the strobe or the reserved code would wipe them. Bit 17 is enabled alone to catch an off-by-one range on the normal line, and bit 0 is enabled alone to show it reaches only the fast line. Masked pending sources are checked to keep both lines high while they stay recorded, and an asynchronous reset is applied mid-run with everything active.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned NSRC_DEF = 18;

  typedef enum logic [1:0] {
    CMD_ENABLE  = 2'b00,
    CMD_DISABLE = 2'b01,
    CMD_CLEAR   = 2'b10,
    CMD_NOP     = 2'b11
  } irq_cmd_e;
endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
  import irq_agg_pkg::*;
#(
  parameter int unsigned NSRC = NSRC_DEF
) (
  input  logic            wr_en_i,
  input  logic [1:0]      cmd_i,
  input  logic [NSRC-1:0] data_i,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] dis_o,
  output logic [NSRC-1:0] clr_o
);
  irq_cmd_e cmd;
  assign cmd = irq_cmd_e'(cmd_i);

  always_comb begin
    en_o  = '0;
    dis_o = '0;
    clr_o = '0;
    if (wr_en_i) begin
      case (cmd)
        CMD_ENABLE:  en_o  = data_i;
        CMD_DISABLE: dis_o = data_i;
        CMD_CLEAR:   clr_o = data_i;
        default:     ;
      endcase
    end
  end

  always_comb begin
    assert ((en_o & dis_o) == '0 && (en_o & clr_o) == '0 && (dis_o & clr_o) == '0)
      else $error("p_cmd_exclusive_r9 violated");
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_agg_pkg::*;
#(
  parameter int unsigned NSRC = NSRC_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] dis_i,
  output logic [NSRC-1:0] mask_o
);
  logic [NSRC-1:0] mask_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       mask_q[i] <= 1'b0;
      else if (dis_i[i]) mask_q[i] <= 1'b0;
      else if (en_i[i])  mask_q[i] <= 1'b1;
    end

    p_enable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i[i] && !dis_i[i] |=> mask_q[i]);
    p_disable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dis_i[i] |=> !mask_q[i]);
    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[i] && !dis_i[i] |=> $stable(mask_q[i]));
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_agg_pkg::*;
#(
  parameter int unsigned NSRC = NSRC_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] pend_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    // set has priority over clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_q[i] <= 1'b0;
      else if (set_i[i]) pend_q[i] <= 1'b1;
      else if (clr_i[i]) pend_q[i] <= 1'b0;
    end

    p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> pend_q[i]);
    p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_q[i] && !clr_i[i] |=> pend_q[i]);
    p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[i] && !set_i[i] |=> !pend_q[i]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_line_combine.sv
module irq_line_combine
  import irq_agg_pkg::*;
#(
  parameter int unsigned NSRC     = NSRC_DEF,
  parameter int unsigned FAST_IDX = 0
) (
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] mask_i,
  output logic            fiq_no,
  output logic            irq_no
);
  logic [NSRC-1:0] active;
  logic [NSRC-1:0] norm_vec;

  assign active = pend_i & mask_i;

  for (genvar i = 0; i < NSRC; i++) begin : g_norm
    if (i == FAST_IDX) begin : g_fast
      assign norm_vec[i] = 1'b0;
    end else begin : g_slow
      assign norm_vec[i] = active[i];
    end
  end

  assign fiq_no = ~active[FAST_IDX];
  assign irq_no = ~|norm_vec;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NSRC = NSRC_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_cmd_i,
  input  logic [NSRC-1:0] wr_data_i,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] mask_o,
  output logic            fiq_no,
  output logic            irq_no
);
  localparam int unsigned FAST_IDX = 0;

  logic [NSRC-1:0] en_vec, dis_vec, clr_vec;

  irq_cmd_decode #(.NSRC(NSRC)) u_dec (
    .wr_en_i (wr_en_i),
    .cmd_i   (wr_cmd_i),
    .data_i  (wr_data_i),
    .en_o    (en_vec),
    .dis_o   (dis_vec),
    .clr_o   (clr_vec)
  );

  irq_mask_reg #(.NSRC(NSRC)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_vec),
    .dis_i  (dis_vec),
    .mask_o (mask_o)
  );

  irq_pend_reg #(.NSRC(NSRC)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_i),
    .clr_i  (clr_vec),
    .pend_o (pend_o)
  );

  irq_line_combine #(.NSRC(NSRC), .FAST_IDX(FAST_IDX)) u_comb (
    .pend_i (pend_o),
    .mask_i (mask_o),
    .fiq_no (fiq_no),
    .irq_no (irq_no)
  );

  p_fiq_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fiq_no |-> pend_o[FAST_IDX] && mask_o[FAST_IDX]);
  p_fiq_drive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o[FAST_IDX] && mask_o[FAST_IDX] |-> !fiq_no);
  p_irq_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> |((pend_o & mask_o) >> 1));
  p_masked_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_o == '0 |-> fiq_no && irq_no);
endmodule

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
  localparam int unsigned N = 18;

  typedef struct packed {
    logic [3:0]   req;
    logic [N-1:0] set;
    logic         wen;
    logic [1:0]   cmd;
    logic [N-1:0] data;
    logic [N-1:0] pend;
    logic [N-1:0] mask;
    logic         fiq;
    logic         irq;
  } vec_t;

  localparam int NV = 15;
  // req, set, wen, cmd, data, exp pend, exp mask, exp fiq_no, exp irq_no
  localparam vec_t TBL [NV] = '{
    '{4'd10, 18'h00001, 1'b0, 2'd0, 18'h00000, 18'h00001, 18'h00000, 1'b1, 1'b1}, // R10
    '{4'd3,  18'h00000, 1'b1, 2'd0, 18'h00001, 18'h00001, 18'h00001, 1'b0, 1'b1}, // R3
    '{4'd2,  18'h00022, 1'b0, 2'd0, 18'h00000, 18'h00023, 18'h00001, 1'b0, 1'b1}, // R2
    '{4'd2,  18'h00000, 1'b0, 2'd0, 18'h00000, 18'h00023, 18'h00001, 1'b0, 1'b1}, // R2 sticky
    '{4'd8,  18'h00000, 1'b1, 2'd0, 18'h00020, 18'h00023, 18'h00021, 1'b0, 1'b0}, // R8
    '{4'd4,  18'h00000, 1'b1, 2'd1, 18'h00001, 18'h00023, 18'h00020, 1'b1, 1'b0}, // R4
    '{4'd5,  18'h00000, 1'b1, 2'd2, 18'h00020, 18'h00003, 18'h00020, 1'b1, 1'b1}, // R5
    '{4'd9,  18'h00000, 1'b1, 2'd3, 18'h3FFFF, 18'h00003, 18'h00020, 1'b1, 1'b1}, // R9 nop
    '{4'd9,  18'h00000, 1'b0, 2'd0, 18'h3FFFF, 18'h00003, 18'h00020, 1'b1, 1'b1}, // R9 no strobe
    '{4'd6,  18'h20000, 1'b1, 2'd2, 18'h20002, 18'h20001, 18'h00020, 1'b1, 1'b1}, // R6
    '{4'd8,  18'h00000, 1'b1, 2'd0, 18'h20000, 18'h20001, 18'h20020, 1'b1, 1'b0}, // R8 bit 17
    '{4'd3,  18'h00000, 1'b1, 2'd0, 18'h00000, 18'h20001, 18'h20020, 1'b1, 1'b0}, // R3 zero data
    '{4'd7,  18'h00000, 1'b1, 2'd0, 18'h00001, 18'h20001, 18'h20021, 1'b0, 1'b0}, // R7
    '{4'd4,  18'h00000, 1'b1, 2'd1, 18'h3FFFF, 18'h20001, 18'h00000, 1'b1, 1'b1}, // R4 all
    '{4'd5,  18'h00000, 1'b1, 2'd2, 18'h3FFFF, 18'h00000, 18'h00000, 1'b1, 1'b1}  // R5 all
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] set_i = '0;
  logic         wr_en_i = 1'b0;
  logic [1:0]   wr_cmd_i = 2'd0;
  logic [N-1:0] wr_data_i = '0;
  logic [N-1:0] pend_o, mask_o;
  logic         fiq_no, irq_no;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  irq_aggregator #(.NSRC(N)) u0 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_i),
    .wr_en_i   (wr_en_i),
    .wr_cmd_i  (wr_cmd_i),
    .wr_data_i (wr_data_i),
    .pend_o    (pend_o),
    .mask_o    (mask_o),
    .fiq_no    (fiq_no),
    .irq_no    (irq_no)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic [N-1:0] p, input logic [N-1:0] m,
                           input logic f, input logic i);
    check({tag, " pend"}, pend_o, p);
    check({tag, " mask"}, mask_o, m);
    check({tag, " fiq_no"}, {{(N-1){1'b0}}, fiq_no}, {{(N-1){1'b0}}, f});
    check({tag, " irq_no"}, {{(N-1){1'b0}}, irq_no}, {{(N-1){1'b0}}, i});
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check_all("R1 reset", '0, '0, 1'b1, 1'b1);
    rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk_i);
      set_i     = TBL[k].set;
      wr_en_i   = TBL[k].wen;
      wr_cmd_i  = TBL[k].cmd;
      wr_data_i = TBL[k].data;
      @(negedge clk_i);
      set_i   = '0;
      wr_en_i = 1'b0;
      check_all($sformatf("R%0d row %0d", TBL[k].req, k),
                TBL[k].pend, TBL[k].mask, TBL[k].fiq, TBL[k].irq);
    end

    // R7 R8 with every source active, then R1 async reset mid-run
    set_i = '1;
    wr_en_i = 1'b1;
    wr_cmd_i = 2'd0;
    wr_data_i = '1;
    @(negedge clk_i);
    set_i = '0;
    wr_en_i = 1'b0;
    check_all("R7 R8 all active", '1, '1, 1'b0, 1'b0);
    #3 rst_ni = 1'b0;
    #2 check_all("R1 async reset", '0, '0, 1'b1, 1'b1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1 after release", '0, '0, 1'b1, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      repeat (2000) @(posedge clk_i);
    join_any
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule